// File: doc/BRIEF.md
# GPIO Event Detector with Interrupt

This block watches a word of general-purpose input pins and turns activity on them into sticky per-pin event flags and one interrupt request. Each cycle it forms the effective input word: the resolved pin level, gated by a per-pin input-enable and then optionally inverted per pin. It compares that word with the value it held one cycle earlier, and sets a status flag for every pin whose trigger condition is met.

Each pin picks its trigger with two configuration bits. With the type bit at 0, the pin is level-sensitive and flags while its input is high. With the type bit at 1, the pin is edge-sensitive and flags on a low-to-high change. If its both-edges bit is also 1, it flags on a change in either direction. The flags stay set until software clears them through a write-one-to-clear strobe with a mask. A new trigger in the same cycle as its clear keeps the bit set. The interrupt line is high while any flagged pin is also enabled.

The register bus decode and the electrical pin model sit outside this block. All configuration arrives as plain vectors.

Top module: `gpio_evt_top`

## Requirements
- R1: `din_o` equals `(pin_lvl_i & in_en_i) ^ invert_i` in the same cycle, with no register on the path.
- R2: A pin with type bit 0 (level mode) sets its status bit in the cycle after a clock edge at which its `din_o` bit was 1.
- R3: A pin with type bit 1 and both-edges bit 1 sets its status bit after any edge at which its `din_o` bit differs from its value at the previous edge. The previous value is held in a register that resets to 0.
- R4: A pin with type bit 1 and both-edges bit 0 sets its status bit only on a 0-to-1 change of `din_o`. A 1-to-0 change or a steady level leaves it unchanged.
- R5: A status bit, once set, stays set until a clear removes it.
- R6: When `clr_stb_i` is 1 at a clock edge, every status bit whose `clr_mask_i` bit is 1 becomes 0 after that edge, unless R7 applies. Bits with mask 0 are kept. With `clr_stb_i` at 0, the mask has no effect.
- R7: If a trigger and a clear hit the same bit at the same edge, the bit stays set. In particular, a level-mode pin that is still high cannot be cleared.
- R8: `irq_o` equals the OR of `status_o & evt_en_i`. It is combinational in `evt_en_i`, and follows the status register with no extra delay.
- R9: During reset `status_o` is 0 and `irq_o` is 0. The previous-input register resets to 0, so an edge-mode pin that is high at the first edge after reset registers a rising edge.
- R10: Pins whose enable bit is 0 still collect status. Setting the enable bit later raises `irq_o` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pin_lvl_i | input | NPINS | Resolved pin levels |
| in_en_i | input | NPINS | Per-pin input enable (0 forces the raw input to 0) |
| invert_i | input | NPINS | Per-pin input inversion |
| evt_type_i | input | NPINS | 0 = level, 1 = edge |
| evt_both_i | input | NPINS | With type 1: 1 = both edges, 0 = rising only |
| evt_en_i | input | NPINS | Per-pin interrupt enable |
| clr_stb_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | NPINS | Status bits to clear when the strobe is 1 |
| din_o | output | NPINS | Effective input word |
| status_o | output | NPINS | Sticky event flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The status register is visible on `status_o`, so a wrong flag shows at the port one cycle after the edge that produced it. If the previous-input register were wrong, the first symptom would be a missing or spurious edge flag, one cycle after the bad comparison. An unmasked flag reaches `irq_o` in the same cycle it appears. A bench model that tracks both registers therefore finds any divergence within one cycle of its cause. The random stimulus mixes modes, inversions, enables and clears, so every pairing of trigger and clear comes up often.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_BOTH  = 2'd2
    } trig_mode_e;

    // Type bit 0 selects level; otherwise the both-edges bit picks the edge kind.
    function automatic trig_mode_e mode_of(input logic edge_sel, input logic both_sel);
        if (!edge_sel)
            return TRIG_LEVEL;
        else if (both_sel)
            return TRIG_BOTH;
        else
            return TRIG_RISE;
    endfunction

endpackage

// File: rtl/gpio_evt_din.sv
module gpio_evt_din #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] pin_lvl_i,
    input  logic [NPINS-1:0] in_en_i,
    input  logic [NPINS-1:0] invert_i,
    output logic [NPINS-1:0] din_o
);
    always_comb begin
        din_o = (pin_lvl_i & in_en_i) ^ invert_i;
    end
endmodule

// File: rtl/gpio_evt_trig.sv
module gpio_evt_trig
    import gpio_evt_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] din_i,
    input  logic [NPINS-1:0] prev_i,
    input  logic [NPINS-1:0] evt_type_i,
    input  logic [NPINS-1:0] evt_both_i,
    output logic [NPINS-1:0] hit_o
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_mode_e mode;
        assign mode = mode_of(evt_type_i[i], evt_both_i[i]);

        always_comb begin
            unique case (mode)
                TRIG_LEVEL: hit_o[i] = din_i[i];
                TRIG_RISE:  hit_o[i] = din_i[i] & ~prev_i[i];
                TRIG_BOTH:  hit_o[i] = din_i[i] ^ prev_i[i];
                default:    hit_o[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_evt_irq.sv
module gpio_evt_irq #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] status_i,
    input  logic [NPINS-1:0] enable_i,
    output logic             irq_o
);
    always_comb begin
        irq_o = |(status_i & enable_i);
    end
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top #(
    parameter int NPINS = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] pin_lvl_i,
    input  logic [NPINS-1:0] in_en_i,
    input  logic [NPINS-1:0] invert_i,
    input  logic [NPINS-1:0] evt_type_i,
    input  logic [NPINS-1:0] evt_both_i,
    input  logic [NPINS-1:0] evt_en_i,
    input  logic             clr_stb_i,
    input  logic [NPINS-1:0] clr_mask_i,
    output logic [NPINS-1:0] din_o,
    output logic [NPINS-1:0] status_o,
    output logic             irq_o
);
    localparam int W = NPINS;

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] din_w;
    logic [W-1:0] hit_w;
    logic [W-1:0] clr_w;

    gpio_evt_din #(.NPINS(W)) u_din (
        .pin_lvl_i (pin_lvl_i),
        .in_en_i   (in_en_i),
        .invert_i  (invert_i),
        .din_o     (din_w)
    );

    gpio_evt_trig #(.NPINS(W)) u_trig (
        .din_i      (din_w),
        .prev_i     (st_q.prev),
        .evt_type_i (evt_type_i),
        .evt_both_i (evt_both_i),
        .hit_o      (hit_w)
    );

    always_comb begin
        st_d      = st_q;
        clr_w     = clr_stb_i ? clr_mask_i : '0;
        st_d.prev = din_w;
        // A hit in the same cycle overrides the clear.
        st_d.stat = (st_q.stat & ~clr_w) | hit_w;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    gpio_evt_irq #(.NPINS(W)) u_irq (
        .status_i (st_q.stat),
        .enable_i (evt_en_i),
        .irq_o    (irq_o)
    );

    assign din_o    = din_w;
    assign status_o = st_q.stat;
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk #(
    parameter int NPINS = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [NPINS-1:0] pin_lvl_i,
    input logic [NPINS-1:0] in_en_i,
    input logic [NPINS-1:0] invert_i,
    input logic [NPINS-1:0] evt_type_i,
    input logic [NPINS-1:0] evt_both_i,
    input logic [NPINS-1:0] evt_en_i,
    input logic             clr_stb_i,
    input logic [NPINS-1:0] clr_mask_i,
    input logic [NPINS-1:0] din_o,
    input logic [NPINS-1:0] status_o,
    input logic             irq_o
);
    logic [NPINS-1:0] seen_q;
    logic [NPINS-1:0] trig_c;
    logic [NPINS-1:0] clr_c;
    logic [NPINS-1:0] keep_c;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) seen_q <= '0;
        else         seen_q <= din_o;
    end

    always_comb begin
        trig_c = (~evt_type_i & din_o)
               | (evt_type_i & evt_both_i & (din_o ^ seen_q))
               | (evt_type_i & din_o & ~seen_q);
        clr_c  = clr_stb_i ? clr_mask_i : '0;
        keep_c = status_o & ~clr_c;
    end

    p_din_map_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        din_o == ((pin_lvl_i & in_en_i) ^ invert_i));

    // Covers R2, R3, R4 and R7: a trigger always leaves its bit set.
    p_trig_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & $past(trig_c)) == $past(trig_c)));

    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & $past(keep_c)) == $past(keep_c)));

    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_o & ~$past(keep_c | trig_c)) == '0));

    p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (|(status_o & evt_en_i)));

    p_reset_r9: assert property (@(posedge clk_i)
        !rst_ni |=> (status_o == '0));
endmodule

bind gpio_evt_top gpio_evt_chk #(.NPINS(NPINS)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_lvl_i  (pin_lvl_i),
    .in_en_i    (in_en_i),
    .invert_i   (invert_i),
    .evt_type_i (evt_type_i),
    .evt_both_i (evt_both_i),
    .evt_en_i   (evt_en_i),
    .clr_stb_i  (clr_stb_i),
    .clr_mask_i (clr_mask_i),
    .din_o      (din_o),
    .status_o   (status_o),
    .irq_o      (irq_o)
);

// File: tb/gpio_evt_top_tb.sv
module gpio_evt_top_tb;
    localparam int N = 32;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [N-1:0] pin_lvl_i = '0, in_en_i = '0, invert_i = '0;
    logic [N-1:0] evt_type_i = '0, evt_both_i = '0, evt_en_i = '0;
    logic         clr_stb_i = 1'b0;
    logic [N-1:0] clr_mask_i = '0;
    logic [N-1:0] din_o, status_o;
    logic         irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [N-1:0] exp_stat = '0;
    logic [N-1:0] exp_prev = '0;
    logic [N-1:0] exp_din  = '0;

    always #5 clk_i = ~clk_i;

    gpio_evt_top #(.NPINS(N)) u_dut (.*);

    function automatic logic [N-1:0] f_din(logic [N-1:0] p, logic [N-1:0] e, logic [N-1:0] v);
        return (p & e) ^ v;
    endfunction

    function automatic logic [N-1:0] f_trig(logic [N-1:0] d, logic [N-1:0] pv,
                                            logic [N-1:0] et, logic [N-1:0] bt);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (!et[i])     r[i] = d[i];
            else if (bt[i]) r[i] = d[i] ^ pv[i];
            else            r[i] = d[i] & ~pv[i];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge: checks outputs, applies new inputs, advances the model.
    task automatic cyc(input string tag, input logic [N-1:0] p, input logic [N-1:0] ie,
                       input logic [N-1:0] inv, input logic [N-1:0] et, input logic [N-1:0] bt,
                       input logic [N-1:0] en, input logic stb, input logic [N-1:0] msk);
        chk(tag, "status", status_o, exp_stat);
        chk(tag, "irq", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(exp_stat & evt_en_i)});
        pin_lvl_i = p; in_en_i = ie; invert_i = inv;
        evt_type_i = et; evt_both_i = bt; evt_en_i = en;
        clr_stb_i = stb; clr_mask_i = msk;
        exp_din = f_din(p, ie, inv);
        #1;
        chk(tag, "din", din_o, exp_din);
        chk(tag, "irq_now", {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, |(exp_stat & en)});
        exp_stat = (exp_stat & ~(stb ? msk : '0)) | f_trig(exp_din, exp_prev, et, bt);
        exp_prev = exp_din;
        @(negedge clk_i);
    endtask

    localparam logic [N-1:0] ONES = '1;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk_i);
        chk("R9", "reset status", status_o, '0);
        chk("R9", "reset irq", {{(N-1){1'b0}}, irq_o}, '0);
        rst_ni = 1'b1;
        // R9: pin 0 high in rising mode at the first edge after reset
        cyc("R9", 32'h1, ONES, '0, 32'h1, '0, ONES, 0, '0);
        cyc("R9", 32'h1, ONES, '0, 32'h1, '0, ONES, 1, ONES);
        cyc("R9", 32'h1, ONES, '0, 32'h1, '0, ONES, 0, '0);
        // R2 and R7: level pin 1 high, clear while still high
        cyc("R2", 32'h2, ONES, '0, '0, '0, ONES, 0, '0);
        cyc("R7", 32'h2, ONES, '0, '0, '0, ONES, 1, ONES);
        cyc("R7", 32'h2, ONES, '0, '0, '0, ONES, 0, '0);
        cyc("R2", 32'h0, ONES, '0, '0, '0, ONES, 1, ONES);
        cyc("R6", 32'h0, ONES, '0, '0, '0, ONES, 0, '0);
        // R4: rising-only pin 4, rise then fall
        cyc("R4", 32'h0, ONES, '0, ONES, '0, ONES, 0, '0);
        cyc("R4", 32'h10, ONES, '0, ONES, '0, ONES, 0, '0);
        cyc("R4", 32'h10, ONES, '0, ONES, '0, ONES, 1, ONES);
        cyc("R4", 32'h0, ONES, '0, ONES, '0, ONES, 0, '0);
        cyc("R4", 32'h0, ONES, '0, ONES, '0, ONES, 0, '0);
        // R3: both-edge pin 5, fall sets
        cyc("R3", 32'h20, ONES, '0, ONES, ONES, ONES, 0, '0);
        cyc("R3", 32'h20, ONES, '0, ONES, ONES, ONES, 1, ONES);
        cyc("R3", 32'h0, ONES, '0, ONES, ONES, ONES, 0, '0);
        cyc("R3", 32'h0, ONES, '0, ONES, ONES, ONES, 0, '0);
        // R1: inversion and input gating
        cyc("R1", 32'hF0F0, 32'hFF00, 32'h0FF0, ONES, '0, ONES, 1, ONES);
        cyc("R1", 32'hF0F0, 32'hFF00, 32'h0FF0, ONES, '0, ONES, 0, '0);
        // R10: disabled pin collects status, enable later raises irq at once
        cyc("R10", '0, ONES, '0, ONES, '0, '0, 1, ONES);
        cyc("R10", 32'h100, ONES, '0, ONES, '0, '0, 0, '0);
        cyc("R10", 32'h100, ONES, '0, ONES, '0, '0, 0, '0);
        cyc("R10", 32'h100, ONES, '0, ONES, '0, 32'h100, 0, '0);
        cyc("R8", 32'h100, ONES, '0, ONES, '0, '0, 0, '0);
        // R5 and R6: random mix
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] p;
            p = pin_lvl_i ^ ($urandom() & $urandom() & $urandom());
            cyc("R5 R6 random", p, ~($urandom() & $urandom()), $urandom() & $urandom() & $urandom(),
                $urandom() | $urandom(), $urandom(), $urandom(),
                ($urandom() % 4) == 0, $urandom());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule